// File: doc/BRIEF.md
# Dithered Phase-Accumulating I/Q Modulator

The block synthesises a carrier digitally and mixes a stream of complex baseband samples onto it. Each accepted sample advances a 32-bit phase register by a programmable tuning word. A small pseudo-random offset can be added to the least significant phase bits before the phase is cut down to a table address. This spreads the spurs that truncation would otherwise produce. The truncated phase reads a sine/cosine table that is computed at elaboration. The incoming I and Q words are then multiplied by the carrier and combined into one real output word.

The block takes one sample per clock when `valid_in` is high. A sample comes out a fixed number of cycles later, marked by `valid_out`. Cycles without a valid input form bubbles. During a bubble the phase and the dither generator stay unchanged and the output word holds its last value.

Top module: `dds_iq_modulator`

## Requirements
- R1: The phase register starts at 0. Each accepted sample uses the current register value as its phase, and the register then adds `tune_word` modulo 2^32, so sample n uses the sum of the earlier tuning words.
- R2: When `valid_in` is low, the phase register, the dither generator and the output word keep their values.
- R3: When `dither_en` is 1, bits [4:0] of the dither generator, zero-extended, are added modulo 2^32 to the sample's phase before the address is taken. When `dither_en` is 0, nothing is added. The table address is bits [31:22] of the result.
- R4: The dither generator is a 16-bit shift register seeded with 16'hACE1 after reset. On each accepted sample it shifts left and takes as its new bit 0 the XOR of bits 15, 13, 12 and 10. It advances whether dither is enabled or not, and it never reaches zero.
- R5: Table entry k (0..1023) holds round-half-away-from-zero of 131071·sin(2πk/1024). The sine of address a is entry a, and the cosine of address a is entry (a+256) mod 1024.
- R6: The output is (I·cos − Q·sin + 4096) shifted arithmetically right by 13 bits, where I and Q are signed 16-bit values.
- R7: A result above 524287 is clamped to 524287 and one below −524288 is clamped to −524288.
- R8: `valid_out` repeats `valid_in` exactly 4 cycles later, bubbles included, and each output word belongs to the sample accepted 4 cycles earlier.
- R9: During and right after reset, `valid_out` and `mod_out` are 0.
- R10: `mod_out` changes only in cycles in which `valid_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Marks an input sample |
| tune_word | input | 32 | Phase increment per accepted sample |
| dither_en | input | 1 | Adds the pseudo-random phase offset |
| i_in | input | 16 | In-phase sample, signed |
| q_in | input | 16 | Quadrature sample, signed |
| valid_out | output | 1 | Marks an output word |
| mod_out | output | 20 | Modulated output, signed |

## Verification
The bench builds the block with its default parameters: a 32-bit phase, a 10-bit address, 18-bit amplitude, 16-bit inputs, a 20-bit output and a 13-bit output shift. That shift is small enough that large in-phase and quadrature inputs at 315° push the result past both clamp limits. A tuning word close to a full turn exercises wrap-around, and a phase parked 16 steps below an address boundary lets the 5-bit dither move the address across it. Random traffic with bubbles then covers latency alignment and the hold behaviour.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int PHASE_W   = 32;
  localparam int ADDR_W    = 10;
  localparam int AMP_W     = 18;
  localparam int IN_W      = 16;
  localparam int OUT_W     = 20;
  localparam int DITH_W    = 5;
  localparam int LFSR_W    = 16;
  localparam int OUT_SHIFT = 13;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
  localparam int PIPE_LAT  = 4;
  localparam real TWO_PI   = 6.283185307179586;

  function automatic int round_away(input real x);
    if (x >= 0.0) return $rtoi(x + 0.5);
    else          return -$rtoi(0.5 - x);
  endfunction
endpackage

// File: rtl/dds_phase_gen.sv
module dds_phase_gen
  import dds_pkg::*;
#(
  parameter int PW = PHASE_W,
  parameter int AW = ADDR_W,
  parameter int DW = DITH_W,
  parameter int LW = LFSR_W,
  parameter logic [LW-1:0] SEED = LFSR_SEED,
  parameter logic [LW-1:0] TAPS = LFSR_TAPS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_in,
  input  logic [PW-1:0] tune_word,
  input  logic          dither_en,
  output logic [AW-1:0] addr_q,
  output logic          addr_vld_q,
  output logic [PW-1:0] acc_q,
  output logic [LW-1:0] lfsr_q
);
  logic [PW-1:0] acc_d;
  logic [LW-1:0] lfsr_d;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] dith;
  logic [PW-1:0] dith_phase;
  logic          fb;

  always_comb begin
    fb         = ^(lfsr_q & TAPS);
    dith       = dither_en ? lfsr_q[DW-1:0] : '0;
    dith_phase = acc_q + PW'(dith);
    acc_d      = acc_q;
    lfsr_d     = lfsr_q;
    addr_d     = addr_q;
    if (valid_in) begin
      acc_d  = acc_q + tune_word;
      lfsr_d = {lfsr_q[LW-2:0], fb};
      addr_d = dith_phase[PW-1 -: AW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= '0;
      lfsr_q     <= SEED;
      addr_q     <= '0;
      addr_vld_q <= 1'b0;
    end else begin
      acc_q      <= acc_d;
      lfsr_q     <= lfsr_d;
      addr_q     <= addr_d;
      addr_vld_q <= valid_in;
    end
  end
endmodule

// File: rtl/dds_sincos_rom.sv
module dds_sincos_rom
  import dds_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int MW = AMP_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        addr,
  input  logic                 addr_vld,
  output logic signed [MW-1:0] sin_q,
  output logic signed [MW-1:0] cos_q,
  output logic                 wave_vld_q
);
  localparam int  DEPTH   = 1 << AW;
  localparam logic [AW-1:0] QUARTER = AW'(DEPTH / 4);
  localparam real PEAK    = real'((1 << (MW - 1)) - 1);

  logic signed [MW-1:0] wave_tab [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_tab
    localparam real ANG = TWO_PI * real'(k) / real'(DEPTH);
    localparam int  VAL = round_away(PEAK * $sin(ANG));
    assign wave_tab[k] = MW'(VAL);
  end

  logic signed [MW-1:0] sin_d, cos_d;
  logic [AW-1:0]        cos_addr;

  always_comb begin
    cos_addr = addr + QUARTER;
    sin_d    = sin_q;
    cos_d    = cos_q;
    if (addr_vld) begin
      sin_d = wave_tab[addr];
      cos_d = wave_tab[cos_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sin_q      <= '0;
      cos_q      <= '0;
      wave_vld_q <= 1'b0;
    end else begin
      sin_q      <= sin_d;
      cos_q      <= cos_d;
      wave_vld_q <= addr_vld;
    end
  end
endmodule

// File: rtl/dds_mixer.sv
module dds_mixer
  import dds_pkg::*;
#(
  parameter int IW = IN_W,
  parameter int MW = AMP_W,
  parameter int OW = OUT_W,
  parameter int SH = OUT_SHIFT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [IW-1:0] i_val,
  input  logic signed [IW-1:0] q_val,
  input  logic signed [MW-1:0] cos_val,
  input  logic signed [MW-1:0] sin_val,
  input  logic                 in_vld,
  output logic signed [OW-1:0] out_q,
  output logic                 out_vld_q
);
  localparam int PROD_W = IW + MW;
  localparam int SUM_W  = PROD_W + 1;
  localparam logic signed [SUM_W-1:0] RND    = SUM_W'(64'sd1 <<< (SH - 1));
  localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((64'sd1 <<< (OW - 1)) - 64'sd1);
  localparam logic signed [SUM_W-1:0] SAT_LO = SUM_W'(-(64'sd1 <<< (OW - 1)));

  logic signed [PROD_W-1:0] pic_q, pqs_q, pic_d, pqs_d;
  logic                     prod_vld_q;
  logic signed [SUM_W-1:0]  diff, rounded;
  logic signed [OW-1:0]     out_d;

  always_comb begin
    pic_d = pic_q;
    pqs_d = pqs_q;
    if (in_vld) begin
      pic_d = PROD_W'(i_val) * PROD_W'(cos_val);
      pqs_d = PROD_W'(q_val) * PROD_W'(sin_val);
    end
  end

  always_comb begin
    diff    = SUM_W'(pic_q) - SUM_W'(pqs_q);
    rounded = (diff + RND) >>> SH;
    out_d   = out_q;
    if (prod_vld_q) begin
      if (rounded > SAT_HI)      out_d = SAT_HI[OW-1:0];
      else if (rounded < SAT_LO) out_d = SAT_LO[OW-1:0];
      else                       out_d = rounded[OW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pic_q      <= '0;
      pqs_q      <= '0;
      prod_vld_q <= 1'b0;
      out_q      <= '0;
      out_vld_q  <= 1'b0;
    end else begin
      pic_q      <= pic_d;
      pqs_q      <= pqs_d;
      prod_vld_q <= in_vld;
      out_q      <= out_d;
      out_vld_q  <= prod_vld_q;
    end
  end
endmodule

// File: rtl/dds_iq_modulator.sv
module dds_iq_modulator
  import dds_pkg::*;
#(
  parameter int PW = PHASE_W,
  parameter int AW = ADDR_W,
  parameter int MW = AMP_W,
  parameter int IW = IN_W,
  parameter int OW = OUT_W,
  parameter int SH = OUT_SHIFT,
  parameter int LATENCY = PIPE_LAT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_in,
  input  logic [PW-1:0] tune_word,
  input  logic          dither_en,
  input  logic [IW-1:0] i_in,
  input  logic [IW-1:0] q_in,
  output logic          valid_out,
  output logic [OW-1:0] mod_out
);
  localparam int IQ_STAGES = 2;

  logic [AW-1:0]        addr;
  logic                 addr_vld;
  logic [PW-1:0]        phase_acc;
  logic [LFSR_W-1:0]    lfsr_state;
  logic signed [MW-1:0] sin_w, cos_w;
  logic                 wave_vld;
  logic signed [OW-1:0] mix_out;

  dds_phase_gen #(.PW(PW), .AW(AW)) u_phase (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .tune_word(tune_word),
    .dither_en(dither_en), .addr_q(addr), .addr_vld_q(addr_vld),
    .acc_q(phase_acc), .lfsr_q(lfsr_state)
  );

  dds_sincos_rom #(.AW(AW), .MW(MW)) u_rom (
    .clk(clk), .rst_n(rst_n), .addr(addr), .addr_vld(addr_vld),
    .sin_q(sin_w), .cos_q(cos_w), .wave_vld_q(wave_vld)
  );

  // I/Q delay line aligning the samples with the table read
  logic [2*IW-1:0] iq_pipe [IQ_STAGES+1];
  logic            iq_en   [IQ_STAGES];
  assign iq_pipe[0] = {i_in, q_in};
  assign iq_en[0]   = valid_in;
  assign iq_en[1]   = addr_vld;

  for (genvar s = 0; s < IQ_STAGES; s++) begin : g_iq
    logic [2*IW-1:0] nxt;
    always_comb nxt = iq_en[s] ? iq_pipe[s] : iq_pipe[s+1];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) iq_pipe[s+1] <= '0;
      else        iq_pipe[s+1] <= nxt;
    end
  end

  dds_mixer #(.IW(IW), .MW(MW), .OW(OW), .SH(SH)) u_mix (
    .clk(clk), .rst_n(rst_n),
    .i_val(iq_pipe[IQ_STAGES][2*IW-1:IW]), .q_val(iq_pipe[IQ_STAGES][IW-1:0]),
    .cos_val(cos_w), .sin_val(sin_w), .in_vld(wave_vld),
    .out_q(mix_out), .out_vld_q(valid_out)
  );

  assign mod_out = mix_out;
endmodule

// File: rtl/dds_iq_modulator_chk.sv
module dds_iq_modulator_chk
  import dds_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               valid_in,
  input logic [PHASE_W-1:0] tune_word,
  input logic               valid_out,
  input logic [OUT_W-1:0]   mod_out,
  input logic [PHASE_W-1:0] acc,
  input logic [LFSR_W-1:0]  lfsr
);
  logic [2:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   since_rst <= '0;
    else if (since_rst != 3'd7)   since_rst <= since_rst + 3'd1;
  end

  // R1
  a_r1_acc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 0 && valid_in) |=> (acc == $past(acc) + $past(tune_word)));
  // R2
  a_r2_acc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 0 && !valid_in) |=> $stable(acc) && $stable(lfsr));
  // R4
  a_r4_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);
  // R8
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd5) |-> (valid_out == $past(valid_in, 4)));
  // R10
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd2 && !valid_out) |-> $stable(mod_out));
endmodule

bind dds_iq_modulator dds_iq_modulator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .tune_word(tune_word),
  .valid_out(valid_out), .mod_out(mod_out), .acc(phase_acc), .lfsr(lfsr_state)
);

// File: tb/dds_iq_modulator_bench.sv
`timescale 1ns/1ps
module dds_iq_modulator_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_in;
  logic [31:0] tune_word;
  logic        dither_en;
  logic [15:0] i_in, q_in;
  logic        valid_out;
  logic [19:0] mod_out;

  always #10 clk = ~clk;

  dds_iq_modulator u_dds_iq_modulator (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .tune_word(tune_word),
    .dither_en(dither_en), .i_in(i_in), .q_in(q_in),
    .valid_out(valid_out), .mod_out(mod_out)
  );

  int unsigned vectors = 0;
  int unsigned fails   = 0;
  int unsigned cyc     = 0;
  bit          done    = 0;

  // reference model state
  logic [31:0] m_acc;
  logic [15:0] m_lfsr;
  int          exp_val [$];
  int unsigned exp_due [$];
  string       exp_tag [$];
  int          last_out;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ref_round(real x);
    return (x < 0.0) ? -$rtoi(-x + 0.5) : $rtoi(x + 0.5);
  endfunction

  function automatic int ref_wave(int k);
    return ref_round(131071.0 * $sin(6.283185307179586 * real'(k % 1024) / 1024.0));
  endfunction

  function automatic int ref_mix(int iv, int qv, int addr);
    longint c, s, d, r;
    c = ref_wave((addr + 256) % 1024);
    s = ref_wave(addr);
    d = longint'(iv) * c - longint'(qv) * s;
    r = (d + 4096) >>> 13;
    if (r > 524287)  r = 524287;
    if (r < -524288) r = -524288;
    return int'(r);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int sx20(logic [19:0] v);
    return int'($signed(v));
  endfunction

  // one clock: check outputs at negedge, then drive the next inputs
  task automatic step(bit v, logic [31:0] tw, bit den, int iv, int qv, string tag);
    int addr;
    logic [31:0] ph;
    @(negedge clk);
    if (exp_due.size() != 0 && exp_due[0] == cyc) begin
      check(valid_out == 1'b1, "R8", "valid_out", valid_out, 1);
      check(sx20(mod_out) == exp_val[0], exp_tag[0], "mod_out",
            sx20(mod_out), exp_val[0]);
      last_out = exp_val[0];
      void'(exp_due.pop_front()); void'(exp_val.pop_front()); void'(exp_tag.pop_front());
    end else begin
      check(valid_out == 1'b0, "R8", "valid_out idle", valid_out, 0);
      check(sx20(mod_out) == last_out, "R10", "mod_out hold", sx20(mod_out), last_out);
    end
    valid_in  = v;
    tune_word = tw;
    dither_en = den;
    i_in      = 16'(iv);
    q_in      = 16'(qv);
    if (v) begin
      ph   = m_acc + (den ? {27'd0, m_lfsr[4:0]} : 32'd0);
      addr = int'(ph[31:22]);
      exp_val.push_back(ref_mix(iv, qv, addr));
      exp_due.push_back(cyc + 4);
      exp_tag.push_back(tag);
      m_acc  = m_acc + tw;
      m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; valid_in = 0; tune_word = 0; dither_en = 0; i_in = 0; q_in = 0;
    repeat (3) @(negedge clk);
    check(valid_out == 1'b0, "R9", "valid_out in reset", valid_out, 0);
    check(mod_out == 20'd0, "R9", "mod_out in reset", sx20(mod_out), 0);
    rst_n = 1'b1;
    m_acc = 32'd0; m_lfsr = 16'hACE1; last_out = 0;
    exp_val.delete(); exp_due.delete(); exp_tag.delete();
  endtask

  task automatic drain();
    repeat (6) step(0, 32'd0, 0, 0, 0, "R2");
  endtask

  initial begin
    rst_n = 1'b0;
    void'($urandom(32'd20240517));
    do_reset();
    step(0, 0, 0, 0, 0, "R9");
    check(mod_out == 20'd0 && valid_out == 0, "R9", "after reset", sx20(mod_out), 0);

    // R5 R6: phase 0, cosine at peak
    step(1, 32'd0, 0, 32767, 0, "R6");
    step(1, 32'd0, 0, -12345, 999, "R6");
    step(1, 32'h4000_0000, 0, 1000, -2000, "R5");
    step(1, 32'd0, 0, 1000, -2000, "R5");   // phase 90 degrees
    drain();

    // R7: saturation at 315 degrees
    do_reset();
    step(1, 32'hE000_0000, 0, 0, 0, "R1");
    step(1, 32'd0, 0, 32767, 32767, "R7");
    step(1, 32'd0, 0, -32768, -32768, "R7");
    step(1, 32'd0, 0, 32767, -32768, "R7");
    drain();

    // R1: wrap-around with a near-full-turn tuning word
    do_reset();
    for (int n = 0; n < 12; n++) step(1, 32'hFF80_0001, 0, 20000, -15000, "R1");
    // R2: bubbles between samples keep phase
    for (int n = 0; n < 6; n++) begin
      step(0, 32'h1234_5678, 1, 555, 555, "R2");
      step(1, 32'h0100_0000, 0, 20000, 7000, "R2");
    end
    drain();

    // R3 R4: dither pushes phase across an address boundary
    do_reset();
    step(1, 32'h003F_FFF0, 1, 30000, 0, "R3");
    for (int n = 0; n < 40; n++) step(1, 32'd0, 1, 30000, 30000, "R3");
    for (int n = 0; n < 10; n++) step(1, 32'd0, 0, 30000, 30000, "R4");
    drain();

    // random traffic
    for (int n = 0; n < 3000; n++)
      step(($urandom % 4) != 0, $urandom, $urandom % 2,
           int'($signed(16'($urandom))), int'($signed(16'($urandom))), "R8");
    drain();

    check(exp_due.size() == 0, "R8", "pending outputs", exp_due.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++; fails++;
      $display("FAIL R8 watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule